// File: doc/BRIEF.md
# Parallel Line Decoder and Self-Synchronizing Descrambler

This block sits on the receive side of a high-rate serial video link. It comes after the deserializer and its input registers. On every rising edge of the word clock it takes one 20-bit line word and reverses two stages of coding. The first stage is the transition coding, with generator x+1. The second stage is the scrambling, with generator x^9+x^4+1. The block then presents 20 bits of plain data.

The serial order inside each word is least significant bit first: bit 0 is the earliest bit on the line. The block does not frame the output, so the data keeps whatever bit alignment the deserializer happened to choose. A framer further down the chain handles that.

The descrambler is self-synchronizing. Its only state is the last line bit and the last nine transition-decoded bits, so it needs no reset to lock onto a stream. After power-up or an input error, the output is correct again once ten fresh line bits have arrived. A reset clears the output register and restarts a small startup tracker. The tracker raises a flag once the history that feeds the output comes entirely from received bits.

Top module: `rxd_word_descrambler`

## Requirements
- R1: While `rst` is high, `data_out` reads zero and `data_ok` reads low. The first result after `rst` is released also reads `data_ok` low.
- R2: `data_ok` reads high from the second result after reset release onward, and it stays high until `rst` rises again.
- R3: The line word that is present at a rising edge with `rst` low appears, decoded, on `data_out` right after that same edge. This is one cycle of latency.
- R4: Transition decoding takes serial bit n as line[n] XOR line[n-1], where bit 0 of a word follows bit 19 of the previous word.
- R5: The data bit is d[n] = s[n] XOR s[n-4] XOR s[n-9], where s is the transition-decoded stream. The taps reach back across word boundaries into earlier words.
- R6: Inverting every line bit leaves the decoded data unchanged, except for the first word after the polarity changes.
- R7: Fed by a matching x^9+x^4+1 scrambler and x+1 transition coder that start from any state, with any whole-word delay, the block reproduces the source data exactly from the second word onward.
- R8: A line held at all zeros or at all ones for two words decodes to an all-zero data word.
- R9: A corrupted line word disturbs at most that word's result and the result that follows it. Every later word is exact again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive word clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the output and the startup tracker |
| line_in | input | 20 | Deserialized line word, bit 0 earliest on the line |
| data_out | output | 20 | Registered descrambled data word |
| data_ok | output | 1 | High once the history behind `data_out` comes entirely from received bits |

## Verification
The line assertions assume the deserializer delivers a known word on every clock, including during reset. This is why the bench drives defined words from time zero and never leaves `line_in` floating. The startup assertions assume `rst` is held for at least one clock and released cleanly. The bench does this twice, the second time in the middle of a stream. The expected data comes from a bit-serial model in the bench, and for the round-trip cases from the source words themselves. The round-trip stimulus is built by a bench-side serial encoder whose state is randomized, which stands for an arbitrary whole-word delay.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // Default geometry of the receive decoder.
  localparam int unsigned RXD_WORD_W   = 20; // line bits per word clock
  localparam int unsigned RXD_TAP_NEAR = 4;  // near feedback tap of x^9+x^4+1
  localparam int unsigned RXD_TAP_FAR  = 9;  // far tap, also the history depth
endpackage

// File: rtl/rxd_nrzi_undo.sv
// Transition decoding (x+1): each bit is XORed with the line bit before it.
// The last line bit of a word is carried into the next word.
module rxd_nrzi_undo #(
  parameter int unsigned WORD_W = rxd_pkg::RXD_WORD_W
) (
  input  logic              clk,
  input  logic [WORD_W-1:0] line_word,
  output logic [WORD_W-1:0] trans_word
);
  logic tail_q;

  function automatic logic [WORD_W-1:0] undo_nrzi(input logic [WORD_W-1:0] t,
                                                  input logic prev);
    logic [WORD_W:0] ext;
    ext = {t, prev};
    return ext[WORD_W:1] ^ ext[WORD_W-1:0];
  endfunction

  // No reset: self-synchronizing state, valid after one word.
  always_ff @(posedge clk) tail_q <= line_word[WORD_W-1];

  assign trans_word = undo_nrzi(line_word, tail_q);
endmodule

// File: rtl/rxd_descram.sv
// Self-synchronizing descrambler: d[n] = s[n] ^ s[n-NEAR] ^ s[n-FAR].
module rxd_descram #(
  parameter int unsigned WORD_W   = rxd_pkg::RXD_WORD_W,
  parameter int unsigned TAP_NEAR = rxd_pkg::RXD_TAP_NEAR,
  parameter int unsigned TAP_FAR  = rxd_pkg::RXD_TAP_FAR
) (
  input  logic              clk,
  input  logic [WORD_W-1:0] trans_word,
  output logic [WORD_W-1:0] data_word
);
  localparam int unsigned EXT_W = WORD_W + TAP_FAR;

  logic [TAP_FAR-1:0] hist_q;   // hist_q[j] = s[first bit of word - FAR + j]
  logic [EXT_W-1:0]   ext;

  assign ext = {trans_word, hist_q};

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign data_word[i] = ext[i + TAP_FAR] ^ ext[i + TAP_FAR - TAP_NEAR] ^ ext[i];
  end

  // Requires WORD_W >= TAP_FAR: the history comes from the current word only.
  always_ff @(posedge clk) hist_q <= trans_word[WORD_W-1 -: TAP_FAR];
endmodule

// File: rtl/rxd_startup.sv
// Counts line bits since reset until the decode history is fully fed.
module rxd_startup #(
  parameter int unsigned WORD_W  = rxd_pkg::RXD_WORD_W,
  parameter int unsigned TAP_FAR = rxd_pkg::RXD_TAP_FAR
) (
  input  logic clk,
  input  logic rst,
  output logic hist_full
);
  localparam int unsigned NEED  = TAP_FAR + 1;          // history bits per output bit
  localparam int unsigned CNT_W = $clog2(NEED + WORD_W + 1);

  logic [CNT_W-1:0] seen_q;

  assign hist_full = (seen_q >= CNT_W'(NEED));

  always_ff @(posedge clk) begin
    if (rst)             seen_q <= '0;
    else if (!hist_full) seen_q <= seen_q + CNT_W'(WORD_W);
  end

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    hist_full |=> hist_full); // R2
endmodule

// File: rtl/rxd_word_descrambler.sv
module rxd_word_descrambler #(
  parameter int unsigned WORD_W   = rxd_pkg::RXD_WORD_W,
  parameter int unsigned TAP_NEAR = rxd_pkg::RXD_TAP_NEAR,
  parameter int unsigned TAP_FAR  = rxd_pkg::RXD_TAP_FAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] line_in,
  output logic [WORD_W-1:0] data_out,
  output logic              data_ok
);
  logic [WORD_W-1:0] trans_word;  // transition-decoded stream
  logic [WORD_W-1:0] plain_word;  // descrambled, before the output register
  logic              hist_full;   // startup tracker event

  rxd_nrzi_undo #(.WORD_W(WORD_W)) u_nrzi (
    .clk        (clk),
    .line_word  (line_in),
    .trans_word (trans_word)
  );

  rxd_descram #(.WORD_W(WORD_W), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_descram (
    .clk        (clk),
    .trans_word (trans_word),
    .data_word  (plain_word)
  );

  rxd_startup #(.WORD_W(WORD_W), .TAP_FAR(TAP_FAR)) u_startup (
    .clk       (clk),
    .rst       (rst),
    .hist_full (hist_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_ok  <= 1'b0;
    end else begin
      data_out <= plain_word;
      data_ok  <= hist_full;
    end
  end

  AST_PRIME_WORD_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !data_ok); // R1
  AST_OK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    data_ok |=> data_ok); // R2
  AST_ZERO_LINE: assert property (@(posedge clk) disable iff (rst)
    (data_ok && $past(line_in) == '0 && $past(line_in, 2) == '0) |-> data_out == '0); // R8
  AST_ONES_LINE: assert property (@(posedge clk) disable iff (rst)
    (data_ok && $past(line_in) == '1 && $past(line_in, 2) == '1) |-> data_out == '0); // R8
endmodule

// File: tb/rxd_word_descrambler_bench.sv
module rxd_word_descrambler_bench;
  localparam int W          = 20;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] line_in = '0;
  logic [W-1:0] data_out;
  logic         data_ok;

  rxd_word_descrambler u_rxd_word_descrambler (
    .clk(clk), .rst(rst), .line_in(line_in), .data_out(data_out), .data_ok(data_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] d;
    bit           chk;
    bit           vld;
    string        tag;
  } item_t;

  item_t sb[$];
  item_t mi;
  int total = 0;
  int bad   = 0;

  // Bench serial decoder model state.
  logic       m_t  = 1'b0;
  logic [8:0] m_sh = '0;   // m_sh[j] = s[n-1-j]
  // Bench serial encoder state.
  logic       e_t  = 1'b0;
  logic [8:0] e_sh = '0;   // e_sh[j] = x[n-1-j]

  function automatic logic [W-1:0] model_dec(input logic [W-1:0] t);
    logic [W-1:0] r;
    logic s;
    for (int i = 0; i < W; i++) begin
      s    = t[i] ^ m_t;
      m_t  = t[i];
      r[i] = s ^ m_sh[3] ^ m_sh[8];
      m_sh = {m_sh[7:0], s};
    end
    return r;
  endfunction

  function automatic logic [W-1:0] model_enc(input logic [W-1:0] d);
    logic [W-1:0] r;
    logic x;
    for (int i = 0; i < W; i++) begin
      x    = d[i] ^ e_sh[3] ^ e_sh[8];
      e_sh = {e_sh[7:0], x};
      r[i] = x ^ e_t;
      e_t  = r[i];
    end
    return r;
  endfunction

  // Driver: one line word per negedge; pushes the expected result.
  task automatic put(input logic [W-1:0] t, input bit push, input bit use_model,
                     input logic [W-1:0] src, input bit chk, input bit vld,
                     input string tag);
    item_t it;
    logic [W-1:0] md;
    @(negedge clk);
    line_in = t;
    md = model_dec(t);
    if (push) begin
      it.d = use_model ? md : src;
      it.chk = chk; it.vld = vld; it.tag = tag;
      sb.push_back(it);
    end
  endtask

  // Monitor: pops after each edge, once the output has settled.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      mi = sb.pop_front();
      total++;
      if (data_ok !== mi.vld) begin
        bad++;
        $display("FAIL R2 (%s): data_ok=%b expected=%b", mi.tag, data_ok, mi.vld);
      end
      if (mi.chk) begin
        total++;
        if (data_out !== mi.d) begin
          bad++;
          $display("FAIL %s: data_out=%h expected=%h", mi.tag, data_out, mi.d);
        end
      end
    end
  end

  task automatic check_reset_state;
    @(posedge clk); #1;
    total++;
    if (data_out !== '0 || data_ok !== 1'b0) begin
      bad++;
      $display("FAIL R1: data_out=%h data_ok=%b expected=00000 0", data_out, data_ok);
    end
  endtask

  task automatic drain;
    while (sb.size() != 0) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: cycles=100000 expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] src;
    logic [W-1:0] ln;
    // R1: reset state, defined words on the line meanwhile
    for (int k = 0; k < 3; k++) begin
      put(W'($urandom), 1'b0, 1'b1, '0, 1'b0, 1'b0, "R1");
      check_reset_state();
    end
    rst = 1'b0;
    // R1/R2: first result after release is not ok; raw random line words
    put(W'($urandom), 1'b1, 1'b1, '0, 1'b0, 1'b0, "R1");
    for (int k = 0; k < 12; k++) put(W'($urandom), 1'b1, 1'b1, '0, 1'b1, 1'b1, "R3");
    for (int k = 0; k < 12; k++) put(W'($urandom), 1'b1, 1'b1, '0, 1'b1, 1'b1, "R5");
    // R8: constant lines
    for (int k = 0; k < 3; k++) put('0, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R8");
    for (int k = 0; k < 3; k++) put('1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R8");
    // R4/R5: single line transitions at word start, middle and end
    foreach (ln[b]) if (b == 0 || b == 5 || b == W-1) begin
      put(W'(1) << b, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R4");
      put('0, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R5");
      put('0, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R5");
    end
    put(20'h55555, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R4");
    put(20'h55555, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R4");
    // R7: round trip from an arbitrary encoder state
    e_t  = 1'($urandom);
    e_sh = 9'($urandom);
    src = W'($urandom);
    put(model_enc(src), 1'b1, 1'b0, src, 1'b0, 1'b1, "R7");
    for (int k = 0; k < 30; k++) begin
      src = W'($urandom);
      put(model_enc(src), 1'b1, 1'b0, src, 1'b1, 1'b1, "R7");
    end
    // R6: inverted line polarity
    src = W'($urandom);
    put(~model_enc(src), 1'b1, 1'b0, src, 1'b0, 1'b1, "R6");
    for (int k = 0; k < 20; k++) begin
      src = W'($urandom);
      put(~model_enc(src), 1'b1, 1'b0, src, 1'b1, 1'b1, "R6");
    end
    // R9: one corrupted line word
    src = W'($urandom);
    put(~model_enc(src) ^ 20'h80001, 1'b1, 1'b0, src, 1'b0, 1'b1, "R9");
    src = W'($urandom);
    put(~model_enc(src), 1'b1, 1'b0, src, 1'b0, 1'b1, "R9");
    for (int k = 0; k < 10; k++) begin
      src = W'($urandom);
      put(~model_enc(src), 1'b1, 1'b0, src, 1'b1, 1'b1, "R9");
    end
    // R1/R2: reset in mid-stream, then restart
    drain();
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 2; k++) begin
      put(W'($urandom), 1'b0, 1'b1, '0, 1'b0, 1'b0, "R1");
      check_reset_state();
    end
    rst = 1'b0;
    put(W'($urandom), 1'b1, 1'b1, '0, 1'b0, 1'b0, "R1");
    for (int k = 0; k < 6; k++) put(W'($urandom), 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2");
    drain();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule